// File: doc/BRIEF.md
# UART Transmit Holding and Shift Sequencer

This block is the transmit half of a serial port. A host writes bytes into a transmit queue. The queue holds up to sixteen entries in FIFO mode and one entry in single-register mode. Each queued byte waits a fixed number of baud ticks and is then moved into a shift register. From there a full asynchronous character frame is sent on the serial line. The baud tick is an input strobe. Divisor logic and the receiver sit outside the block.

The block keeps two line-status flags. `thre` means the holding side (queue) is empty. `temt` means both the queue and the shifter are empty. These flags change at defined points of the move and shift phases, not when the last bit leaves the line. The block also keeps a transmit-empty interrupt condition, gated by an enable bit written through an interrupt-enable strobe.

The transfer latency depends on the shifter. When the shifter is idle, a byte moves after a fixed wait. When the shifter is busy, the next byte is staged as soon as the current frame's data bits are out, so frames follow each other with no gap. A loopback control delivers each finished byte to a local receive port and keeps the line idle.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset `txd` is 1, `thre` and `temt` are 1, `tx_irq` is 0 and `lb_valid` is 0.
- R2: With `fifo_en`=1 the queue accepts writes while it holds fewer than 16 bytes. With `fifo_en`=0 it holds one byte. A `wr_en` pulse while the queue is full is ignored, and that byte is never sent.
- R3: When the shifter is idle, a written byte is moved into the shift register on the 8th `tick` after the write. The start bit appears on `txd` right after that tick.
- R4: While a frame is shifting and a byte is pending, the byte is staged on the tick that ends the frame's last data bit. The next frame then starts on the tick that ends the current frame, with no idle gap.
- R5: A frame is sent one bit per tick in this order: a low start bit; 5+`dlen` data bits, LSB first; a parity bit if `par_en`=1; and stop bits. The parity bit equals the XOR of the data bits XOR `par_odd`. There are 2 stop bits if `two_stop`=1, otherwise 1. The line is high after the frame.
- R6: A host write clears `thre` and `temt`. `thre` is set again only by a transfer that leaves the queue empty.
- R7: A transfer into the shift register clears `temt`. When a frame ends with no byte staged, `temt` takes the value of `thre`.
- R8: The interrupt condition rises when a transfer empties the queue. It is cleared at the end of each frame and by a host write. An enable write with `ier_txe`=1 while `thre`=1 raises it again. `tx_irq` is the condition ANDed with the enable last written through `ier_wr`/`ier_txe`.
- R9: With `loopback`=1, `txd` stays high and each finished byte appears on `lb_data` with a one-cycle `lb_valid` pulse on the tick that ends the frame. With `loopback`=0, `lb_valid` stays 0.
- R10: `fifo_clr` discards queued bytes and cancels the pending transfer. It sets `thre`, and sets `temt` when the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud tick strobe, one cycle per bit time |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| wr_en | input | 1 | Host data write strobe |
| wr_data | input | 8 | Byte written by the host |
| ier_wr | input | 1 | Interrupt-enable write strobe |
| ier_txe | input | 1 | Transmit-empty enable value written with `ier_wr` |
| loopback | input | 1 | Route finished bytes to `lb_data` instead of the line |
| dlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| fifo_clr | input | 1 | Discard queued bytes |
| txd | output | 1 | Serial output, idles high |
| thre | output | 1 | Holding side empty |
| temt | output | 1 | Holding side and shifter empty |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| lb_valid | output | 1 | Loopback byte strobe |
| lb_data | output | 8 | Loopback byte |

## Verification
The bench sweeps all 32 frame formats bit by bit and checks the exact tick on which each flag changes.

Timing faults it targets:
- An off-by-one in the idle wait would move the start bit a tick early or late.
- Staging the next byte one tick early would set `thre` a tick before the last data bit has left.
- Not staging the next byte would leave a gap between queued frames.

Queue and interrupt faults it targets:
- An overflow fault would let a 17th byte (or a second single-register byte) reach the receive port.
- A design that left the interrupt condition set across frame end, or ignored the enable-write re-raise, would show the wrong `tx_irq` level.
- A broken queue clear would let discarded bytes come out in loopback.

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
  parameter int DEPTH     = 16,
  parameter int IDLE_WAIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fifo_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ier_wr,
  input  logic       ier_txe,
  input  logic       loopback,
  input  logic [1:0] dlen,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       fifo_clr,
  output logic       txd,
  output logic       thre,
  output logic       temt,
  output logic       tx_irq,
  output logic       lb_valid,
  output logic [7:0] lb_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = $clog2(IDLE_WAIT + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] qn;
  logic          pend, busy, nxt, thre_q, temt_q, cond, ie_q, par_q, lbv_q;
  logic [3:0]    pos;
  logic [WW-1:0] wait_q;
  logic [7:0]    sh, ob, lbd_q;

  wire [3:0]    dn      = 4'd5 + {2'b00, dlen};
  wire [3:0]    fb      = dn + 4'd2 + {3'b000, par_en} + {3'b000, two_stop};
  wire [7:0]    dmask   = 8'hFF >> (2'd3 - dlen);
  wire [CW-1:0] cap     = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          accept  = wr_en && (qn < cap);
  wire [7:0]    head    = mem[rp];
  wire          done    = tick && busy && (pos == fb - 4'd1);
  wire          move    = tick && pend && (qn != '0) &&
                          (busy ? (pos >= dn && !nxt) : (wait_q == WW'(IDLE_WAIT - 1)));
  wire          empties = move && (qn == CW'(1)) && !accept;
  wire          launch  = move && (!busy || done);
  wire          ph      = ^(head & dmask) ^ par_odd;
  wire          ps      = ^(sh & dmask) ^ par_odd;
  wire          fbit    = (pos == 4'd0) ? 1'b0 :
                          (pos <= dn) ? sh[0] :
                          (par_en && pos == dn + 4'd1) ? par_q : 1'b1;

  assign txd      = loopback || !busy || fbit;
  assign thre     = thre_q;
  assign temt     = temt_q;
  assign tx_irq   = cond && ie_q;
  assign lb_valid = lbv_q;
  assign lb_data  = lbd_q;

  always_ff @(posedge clk)
    if (accept) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      rp <= '0;
      wp <= '0;
      qn <= '0;
    end else begin
      if (accept) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (move)   rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      qn <= qn + CW'(accept) - CW'(move);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; nxt <= 1'b0; pos <= '0; sh <= '0; ob <= '0; par_q <= 1'b0;
      wait_q <= '0; pend <= 1'b0; thre_q <= 1'b1; temt_q <= 1'b1;
      cond <= 1'b0; ie_q <= 1'b0; lbv_q <= 1'b0; lbd_q <= '0;
    end else begin
      lbv_q <= done && loopback;
      if (done) lbd_q <= ob;

      if (launch) begin
        busy <= 1'b1; pos <= '0; sh <= head; ob <= head; par_q <= ph; nxt <= 1'b0;
      end else if (done && nxt) begin
        pos <= '0; ob <= sh; par_q <= ps; nxt <= 1'b0;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        pos <= pos + 4'd1;
        if (move) begin
          sh  <= head;
          nxt <= 1'b1;
        end else if (pos >= 4'd1 && pos <= dn) begin
          sh <= sh >> 1;
        end
      end

      if (busy || !pend || move) wait_q <= '0;
      else if (tick)             wait_q <= wait_q + WW'(1);

      if (fifo_clr)     pend <= 1'b0;
      else if (accept)  pend <= 1'b1;
      else if (empties) pend <= 1'b0;

      if (fifo_clr)     thre_q <= 1'b1;
      else if (accept)  thre_q <= 1'b0;
      else if (empties) thre_q <= 1'b1;

      if (accept || move)                 temt_q <= 1'b0;
      else if (done && !nxt)              temt_q <= thre_q;
      else if (fifo_clr && !busy && !nxt) temt_q <= 1'b1;

      if (accept)                                           cond <= 1'b0;
      else if (empties || (ier_wr && ier_txe && thre_q))    cond <= 1'b1;
      else if (done)                                        cond <= 1'b0;

      if (ier_wr) ie_q <= ier_txe;
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    qn <= CW'(DEPTH)); // R2
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && qn == cap && !fifo_clr && !move) |=> (qn == $past(qn))); // R2
  AST_THRE_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(thre_q) && !$past(fifo_clr)) |-> !temt_q); // R6
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    temt_q |-> thre_q); // R7
  AST_IRQ_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> thre_q); // R8
  AST_LB_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid |-> $past(busy)); // R9
endmodule

// File: tb/sim_uart_tx_seq.sv
module sim_uart_tx_seq;
  logic clk = 0, rst_n = 0, tick = 0, fifo_en = 0, wr_en = 0, ier_wr = 0, ier_txe = 0;
  logic loopback = 0, par_en = 0, par_odd = 0, two_stop = 0, fifo_clr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] dlen = 0;
  wire txd, thre, temt, tx_irq, lb_valid;
  wire [7:0] lb_data;

  uart_tx_seq u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .fifo_en(fifo_en), .wr_en(wr_en),
    .wr_data(wr_data), .ier_wr(ier_wr), .ier_txe(ier_txe), .loopback(loopback), .dlen(dlen),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .fifo_clr(fifo_clr), .txd(txd),
    .thre(thre), .temt(temt), .tx_irq(tx_irq), .lb_valid(lb_valid), .lb_data(lb_data));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, lb_n = 0, lb0 = 0;
  logic [7:0] lb_last = 0;

  always @(negedge clk) if (lb_valid) begin lb_n++; lb_last = lb_data; end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0; #1;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b; @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic ier(input logic v);
    @(negedge clk); ier_wr = 1; ier_txe = v; @(negedge clk); ier_wr = 0; #1;
  endtask

  task automatic clr();
    @(negedge clk); fifo_clr = 1; @(negedge clk); fifo_clr = 0; #1;
  endtask

  function automatic int ebit(input int p, input logic [7:0] b);
    int d = 5 + int'(dlen);
    logic [7:0] m = 8'hFF >> (2'd3 - dlen);
    if (p == 0) return 0;
    if (p <= d) return int'(b[p-1]);
    if (par_en && p == d + 1) return int'(^(b & m) ^ par_odd);
    return 1;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 txd", txd, 1); chk("R1 thre", thre, 1); chk("R1 temt", temt, 1);
    chk("R1 irq", tx_irq, 0); chk("R1 lb_valid", lb_valid, 0);

    for (int c = 0; c < 32; c++) begin
      logic [7:0] b;
      int f;
      dlen = 2'(c); par_en = c[2]; two_stop = c[3]; par_odd = c[4];
      b = 8'h5A ^ 8'(c * 37);
      f = 7 + int'(dlen) + int'(par_en) + int'(two_stop);
      wr(b);
      chk("R6 write clears thre", thre, 0); chk("R6 write clears temt", temt, 0);
      repeat (7) tk();
      chk("R3 no start before 8th tick", txd, 1);
      tk();
      chk("R3 start bit on 8th tick", txd, 0);
      chk("R6 thre on emptying transfer", thre, 1);
      chk("R7 temt cleared by transfer", temt, 0);
      chk("R8 irq gated by enable", tx_irq, 0);
      for (int p = 1; p < f; p++) begin
        tk();
        chk("R5 frame bit", txd, ebit(p, b));
      end
      tk();
      chk("R7 temt at frame end", temt, 1); chk("R5 line idle after frame", txd, 1);
    end
    chk("R9 no loopback strobe in line mode", lb_n, 0);

    fifo_en = 1; loopback = 1; dlen = 3; par_en = 0; two_stop = 0; par_odd = 0;
    ier(1);
    chk("R8 enable write raises irq when thre", tx_irq, 1);
    wr(8'h11);
    chk("R8 write clears irq", tx_irq, 0);
    wr(8'h22); wr(8'h33);
    for (int t = 1; t <= 38; t++) begin
      tk();
      chk("R9 line held high in loopback", txd, 1);
      chk("R4 back-to-back completions", lb_n, int'(t >= 18) + int'(t >= 28) + int'(t >= 38));
      if (t == 26) chk("R4 no early staging", thre, 0);
      if (t == 27) begin chk("R4 staging at last data bit", thre, 1); chk("R8 irq on empty", tx_irq, 1); end
      if (t == 18) chk("R9 first byte", lb_last, 8'h11);
      if (t == 28) begin chk("R9 second byte", lb_last, 8'h22); chk("R8 irq cleared at frame end", tx_irq, 0); end
      if (t == 38) begin chk("R9 third byte", lb_last, 8'h33); chk("R7 temt after last", temt, 1); end
    end
    ier(1);
    chk("R8 re-raise by enable write", tx_irq, 1);
    lb0 = lb_n;
    wr(8'h44);
    chk("R8 irq cleared by write", tx_irq, 0); chk("R6 thre cleared by write", thre, 0);
    clr();
    chk("R10 thre after clear", thre, 1); chk("R10 temt after clear", temt, 1);
    repeat (30) tk();
    chk("R10 discarded byte not sent", lb_n - lb0, 0);

    lb0 = lb_n;
    for (int i = 0; i < 17; i++) wr(8'(i));
    repeat (8 + 16 * 10 + 5) tk();
    chk("R2 fifo accepts sixteen", lb_n - lb0, 16);
    chk("R2 last accepted byte", lb_last, 8'h0F);

    fifo_en = 0;
    lb0 = lb_n;
    wr(8'hA1); wr(8'hB2);
    repeat (30) tk();
    chk("R2 holding register single byte", lb_n - lb0, 1);
    chk("R2 holding byte kept", lb_last, 8'hA1);

    lb0 = lb_n;
    wr(8'hC3);
    repeat (8) tk();
    chk("R3 thre after idle move", thre, 1);
    wr(8'hD4);
    chk("R6 thre cleared", thre, 0);
    repeat (8) tk();
    chk("R4 busy not yet staged", thre, 0);
    tk();
    chk("R4 busy staged after data bits", thre, 1);
    tk();
    chk("R4 first frame done", lb_n - lb0, 1); chk("R4 first byte", lb_last, 8'hC3);
    repeat (10) tk();
    chk("R4 second frame no gap", lb_n - lb0, 2); chk("R4 second byte", lb_last, 8'hD4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule